// File: doc/BRIEF.md
# Two-Set Line Blink Waveform Generator

This block drives a square wave onto any general-purpose output line that has blinking switched on. Two timing sets, A and B, each keep a high-time and a low-time length counted in clock cycles, and each set runs its own phase counter that produces one shared waveform. Every line then picks set A or set B with its own select bit. Where blinking is on and the line is driven as an output, the line takes that set's waveform in place of its static output data; everywhere else the static data passes through unchanged.

Software programs a length by writing the cycle count into one of the set's two slots. Turning a time into cycles happens in software. A new length does not cut the phase that is running: it takes effect at the next phase boundary, so every pulse on a line has a whole length from one programmed value.

Top module: `blink_pwm_gen`

## Requirements
- R1: While a set's waveform is high, it stays high for the set's programmed high length (in cycles), then turns low.
- R2: While a set's waveform is low, it stays low for the set's programmed low length, then turns high, so one period is the sum of the two lengths.
- R3: A programmed length of 0 gives a phase of exactly 1 cycle.
- R4: A write with `wrEn` high loads `wrData` into set A when `wrWin` is 0 and into set B when `wrWin` is 1; offset 0 selects the high-length slot and offset 4 selects the low-length slot. A write to one set leaves the other set's waveform unchanged.
- R5: A line with blinking on and driven as an output follows set A's waveform when its `setSel` bit is 0 and set B's waveform when it is 1.
- R6: A line whose `blinkEn` bit is 0 outputs its `outData` bit whatever the sets are doing.
- R7: A line whose `lineIsOut` bit is 0 (input direction) outputs its `outData` bit even with blinking on.
- R8: A length written during a phase leaves the running phase at its old length; the new value governs phases that start after the next boundary.
- R9: A write at any offset other than 0 and 4 changes neither length of either set.
- R10: While reset is asserted both sets' waveforms are high, and after reset both lengths are 0 (a period of 2 cycles, one high and one low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all lengths count its cycles |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Length write strobe, one cycle per write |
| wrWin | input | 1 | Timing set written: 0 = A, 1 = B |
| wrOffs | input | 3 | Byte offset in the set's window: 0 high length, 4 low length |
| wrData | input | DUR_W (32) | Length in clock cycles |
| outData | input | LINES (32) | Static output value per line |
| lineIsOut | input | LINES (32) | Per-line direction: 1 = output |
| blinkEn | input | LINES (32) | Per-line blink enable |
| setSel | input | LINES (32) | Per-line timing set: 0 = A, 1 = B |
| pinOut | output | LINES (32) | Per-line value after blinking is applied |

## Verification
A table of length pairs for both sets is applied with line 0 on set A and line 1 on set B, and the high and low run lengths are measured at the pins; asymmetric pairs tell the high slot apart from the low slot, and different values in the two sets show that each line follows only its own set. Entries holding 0 separate the one-cycle floor from an off-by-one in the counter. Directed tests then write a new length in the middle of a high phase to tell a boundary-aligned update from an immediate one, write at unused offsets, and clear the enable and direction bits to show the static data passing through.

// File: rtl/blink_pwm_pkg.sv
package blink_pwm_pkg;
  localparam int NUM_SETS = 2;
  localparam int WIN_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  // Load strobes from the write decoder to the timing datapath.
  typedef struct packed {
    logic [NUM_SETS-1:0] ldOn;
    logic [NUM_SETS-1:0] ldOff;
  } strobe_t;
endpackage

// File: rtl/blink_pwm_ctrl.sv
module blink_pwm_ctrl
  import blink_pwm_pkg::*;
#(
  parameter int OFFS_W   = 3,
  parameter int ON_OFFS  = 0,
  parameter int OFF_OFFS = 4
) (
  input  logic              wrEn,
  input  logic [WIN_W-1:0]  wrWin,
  input  logic [OFFS_W-1:0] wrOffs,
  output strobe_t           strb
);
  localparam logic [OFFS_W-1:0] onAddr  = OFFS_W'(ON_OFFS);
  localparam logic [OFFS_W-1:0] offAddr = OFFS_W'(OFF_OFFS);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (wrOffs == onAddr) begin
        strb.ldOn[wrWin] = 1'b1;
      end else if (wrOffs == offAddr) begin
        strb.ldOff[wrWin] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/blink_pwm_dp.sv
module blink_pwm_dp
  import blink_pwm_pkg::*;
#(
  parameter int LINES = 32,
  parameter int DUR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DUR_W-1:0]   wrData,
  input  logic [LINES-1:0]   outData,
  input  logic [LINES-1:0]   lineIsOut,
  input  logic [LINES-1:0]   blinkEn,
  input  logic [LINES-1:0]   setSel,
  output logic [LINES-1:0]   pinOut,
  output logic [NUM_SETS-1:0] wave,
  output logic [NUM_SETS-1:0] phaseEnd
);
  localparam logic [DUR_W-1:0] oneCnt = DUR_W'(1);

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    logic [DUR_W-1:0] pendOn, pendOff;
    logic [DUR_W-1:0] actOn, actOff;
    logic [DUR_W-1:0] cnt, curLen, lastIdx;
    logic             phaseHigh;

    // A length of zero still lasts one cycle.
    always_comb begin
      curLen  = phaseHigh ? actOn : actOff;
      lastIdx = (curLen == '0) ? '0 : curLen - oneCnt;
    end

    assign phaseEnd[g] = (cnt == lastIdx);
    assign wave[g]     = phaseHigh;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendOn    <= '0;
        pendOff   <= '0;
        actOn     <= '0;
        actOff    <= '0;
        cnt       <= '0;
        phaseHigh <= 1'b1;
      end else begin
        if (strb.ldOn[g])  pendOn  <= wrData;
        if (strb.ldOff[g]) pendOff <= wrData;
        if (phaseEnd[g]) begin
          cnt       <= '0;
          phaseHigh <= ~phaseHigh;
          actOn     <= pendOn;
          actOff    <= pendOff;
        end else begin
          cnt <= cnt + oneCnt;
        end
      end
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      if (blinkEn[i] && lineIsOut[i]) begin
        pinOut[i] = wave[setSel[i]];
      end else begin
        pinOut[i] = outData[i];
      end
    end
  end
endmodule

// File: rtl/blink_pwm_gen.sv
module blink_pwm_gen
  import blink_pwm_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int DUR_W  = 32,
  parameter int OFFS_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrWin,
  input  logic [OFFS_W-1:0] wrOffs,
  input  logic [DUR_W-1:0]  wrData,
  input  logic [LINES-1:0]  outData,
  input  logic [LINES-1:0]  lineIsOut,
  input  logic [LINES-1:0]  blinkEn,
  input  logic [LINES-1:0]  setSel,
  output logic [LINES-1:0]  pinOut
);
  strobe_t             strb;
  logic [NUM_SETS-1:0] wave;
  logic [NUM_SETS-1:0] phaseEnd;

  blink_pwm_ctrl #(.OFFS_W(OFFS_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrWin  (wrWin),
    .wrOffs (wrOffs),
    .strb   (strb)
  );

  blink_pwm_dp #(.LINES(LINES), .DUR_W(DUR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .outData   (outData),
    .lineIsOut (lineIsOut),
    .blinkEn   (blinkEn),
    .setSel    (setSel),
    .pinOut    (pinOut),
    .wave      (wave),
    .phaseEnd  (phaseEnd)
  );
endmodule

// File: rtl/blink_pwm_chk.sv
module blink_pwm_chk
  import blink_pwm_pkg::*;
#(
  parameter int LINES = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [LINES-1:0]    outData,
  input logic [LINES-1:0]    lineIsOut,
  input logic [LINES-1:0]    blinkEn,
  input logic [LINES-1:0]    setSel,
  input logic [LINES-1:0]    pinOut,
  input logic [NUM_SETS-1:0] wave,
  input logic [NUM_SETS-1:0] phaseEnd
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_setchk
    // R8: no phase changes level except at its boundary
    p_hold_phase_r8: assert property (@(posedge clk) disable iff (!rstN)
      !phaseEnd[s] |=> $stable(wave[s]));
    // R1, R2: each boundary flips the level
    p_flip_r1: assert property (@(posedge clk) disable iff (!rstN)
      phaseEnd[s] |=> (wave[s] != $past(wave[s])));
  end

  for (genvar i = 0; i < LINES; i++) begin : g_linechk
    p_idle_line_r6: assert property (@(posedge clk) disable iff (!rstN)
      !blinkEn[i] |-> (pinOut[i] == outData[i]));
    p_input_line_r7: assert property (@(posedge clk) disable iff (!rstN)
      !lineIsOut[i] |-> (pinOut[i] == outData[i]));
    p_route_b_r5: assert property (@(posedge clk) disable iff (!rstN)
      (blinkEn[i] && lineIsOut[i] && setSel[i]) |-> (pinOut[i] == wave[1]));
    p_route_a_r5: assert property (@(posedge clk) disable iff (!rstN)
      (blinkEn[i] && lineIsOut[i] && !setSel[i]) |-> (pinOut[i] == wave[0]));
  end
endmodule

bind blink_pwm_gen blink_pwm_chk #(.LINES(LINES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .outData   (outData),
  .lineIsOut (lineIsOut),
  .blinkEn   (blinkEn),
  .setSel    (setSel),
  .pinOut    (pinOut),
  .wave      (wave),
  .phaseEnd  (phaseEnd)
);

// File: tb/blink_pwm_gen_tb.sv
`timescale 1ns/1ps
module blink_pwm_gen_tb;
  localparam int LINES = 32;
  localparam int DUR_W = 32;
  localparam int NVEC  = 4;
  // Each row: high A, low A, high B, low B
  localparam int unsigned VEC [NVEC][4] = '{
    '{5, 3, 2, 7},
    '{1, 6, 4, 4},
    '{0, 4, 6, 0},
    '{9, 2, 0, 0}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic             wrWin = 1'b0;
  logic [2:0]       wrOffs = '0;
  logic [DUR_W-1:0] wrData = '0;
  logic [LINES-1:0] outData = '0;
  logic [LINES-1:0] lineIsOut = '0;
  logic [LINES-1:0] blinkEn = '0;
  logic [LINES-1:0] setSel = '0;
  logic [LINES-1:0] pinOut;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  blink_pwm_gen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWin(wrWin), .wrOffs(wrOffs),
    .wrData(wrData), .outData(outData), .lineIsOut(lineIsOut),
    .blinkEn(blinkEn), .setSel(setSel), .pinOut(pinOut)
  );

  function automatic int floorOne(int unsigned v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeLen(input bit win, input int offs, input int unsigned val);
    @(negedge clk);
    wrEn = 1'b1; wrWin = win; wrOffs = 3'(offs); wrData = DUR_W'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure(input int line, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (pinOut[line] !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    while (pinOut[line] !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
    while (pinOut[line] === 1'b1 && guard < 500) begin hi++; @(negedge clk); guard++; end
    while (pinOut[line] === 1'b0 && guard < 500) begin lo++; @(negedge clk); guard++; end
  endtask

  // Measures one high run of line 0 and writes set A's high length mid-run.
  task automatic highWithWrite(input int atCnt, input int unsigned val, output int hi);
    int guard = 0;
    hi = 0;
    @(negedge clk);
    while (pinOut[0] !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    while (pinOut[0] !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
    while (pinOut[0] === 1'b1 && guard < 500) begin
      hi++;
      if (hi == atCnt) begin
        wrEn = 1'b1; wrWin = 1'b0; wrOffs = 3'd0; wrData = DUR_W'(val);
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk); guard++;
    end
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hi, lo, mism;
    blinkEn = 32'h3; lineIsOut = '1; setSel = 32'h2; outData = '0;
    repeat (4) @(negedge clk);
    check(pinOut[1:0] == 2'b11, "R10 waves high in reset", int'(pinOut[1:0]), 3);
    rstN = 1'b1;
    measure(0, hi, lo);
    check(hi == 1 && lo == 1, "R10 default period", hi * 10 + lo, 11);

    for (int v = 0; v < NVEC; v++) begin
      writeLen(1'b0, 0, VEC[v][0]);
      writeLen(1'b0, 4, VEC[v][1]);
      writeLen(1'b1, 0, VEC[v][2]);
      writeLen(1'b1, 4, VEC[v][3]);
      repeat (60) @(negedge clk);
      measure(0, hi, lo);
      check(hi == floorOne(VEC[v][0]), "R1 R3 R5 set A high", hi, floorOne(VEC[v][0]));
      check(lo == floorOne(VEC[v][1]), "R2 R3 R5 set A low", lo, floorOne(VEC[v][1]));
      measure(1, hi, lo);
      check(hi == floorOne(VEC[v][2]), "R4 R5 set B high", hi, floorOne(VEC[v][2]));
      check(lo == floorOne(VEC[v][3]), "R4 R5 set B low", lo, floorOne(VEC[v][3]));
    end

    // R4: writing set B only leaves set A alone
    writeLen(1'b0, 0, 5); writeLen(1'b0, 4, 3);
    repeat (30) @(negedge clk);
    writeLen(1'b1, 0, 8);
    repeat (30) @(negedge clk);
    measure(0, hi, lo);
    check(hi == 5 && lo == 3, "R4 set A untouched", hi * 10 + lo, 53);

    // R9: unused offsets are ignored
    writeLen(1'b0, 1, 9); writeLen(1'b0, 2, 9); writeLen(1'b0, 3, 9);
    writeLen(1'b0, 5, 9); writeLen(1'b0, 6, 9); writeLen(1'b0, 7, 9);
    repeat (30) @(negedge clk);
    measure(0, hi, lo);
    check(hi == 5 && lo == 3, "R9 stray offsets ignored", hi * 10 + lo, 53);

    // R8: mid-phase write keeps the running phase
    writeLen(1'b0, 0, 10); writeLen(1'b0, 4, 10);
    repeat (60) @(negedge clk);
    highWithWrite(3, 4, hi);
    check(hi == 10, "R8 running phase keeps old length", hi, 10);
    measure(0, hi, lo);
    check(hi == 4, "R8 next phase uses new length", hi, 4);

    // R6: blinking off passes static data
    blinkEn = 32'h2; outData = 32'h1; mism = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pinOut[0] !== 1'b1) mism++;
    end
    check(mism == 0, "R6 blink disabled", mism, 0);

    // R7: input direction passes static data
    blinkEn = 32'h3; lineIsOut = 32'hFFFF_FFFE; outData = 32'h0; mism = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pinOut[0] !== 1'b0) mism++;
    end
    check(mism == 0, "R7 input line static", mism, 0);

    // R5: line switched to set B follows set B
    lineIsOut = '1; setSel = 32'h3;
    writeLen(1'b1, 0, 3); writeLen(1'b1, 4, 6);
    repeat (40) @(negedge clk);
    measure(0, hi, lo);
    check(hi == 3 && lo == 6, "R5 line 0 on set B", hi * 10 + lo, 36);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule